// File: doc/BRIEF.md
# SPI Serial Clock Rate Generator

This block derives the serial clock of an SPI master from the bus clock. A divide ratio is chosen by three configuration fields: a 2-bit prescaler select, a 4-bit scaler select and a double-rate bit. The prescaler divisor is not a power of two (2, 3, 5 or 7). The double-rate bit halves the product of the two divisors, so the resulting period in bus clocks is prescaler × scaler / (1 + double-rate).

While the run input is high, the block produces a continuous serial clock. It also produces two one-cycle strobes that mark where each period begins (the leading edge, away from the idle level) and where it returns to the idle level (the trailing edge). A data shifter can hook onto these strobes. The idle level comes from the polarity input. Configuration is captured only when a run starts from idle. When run is dropped, the period in progress is completed before the block goes idle again.

Top module: `spi_rate_gen`

## Requirements
- R1: Prescaler select codes 0, 1, 2 and 3 give a divisor of 2, 3, 5 and 7 respectively.
- R2: Scaler select codes 0 to 3 give 2, 4, 6 and 8. Codes 4 to 15 give 16, 32, 64, 128, 256, 512, 1024, 2048, 4096, 8192, 16384 and 32768 in that order.
- R3: While running, consecutive leading strobes are exactly prescaler × scaler / (1 + double-rate) bus clocks apart. Setting the double-rate bit halves the period of an otherwise identical setting. Between strobes, the serial clock does not change.
- R4: The half-period in which the serial clock is high lasts ceil(P/2) bus clocks, and the low half lasts floor(P/2). This holds for either polarity.
- R5: After reset and while idle, both strobes are low. The serial clock equals the polarity input as sampled at the previous clock edge (1 = idle high).
- R6: A run is sampled high at a clock edge while the block is idle. In the cycle after that edge, the leading strobe is high for one cycle and the serial clock is at the inverse of the polarity.
- R7: The trailing strobe is high for one cycle, in the cycle in which the serial clock returns to the polarity level. The two strobes are never high together.
- R8: After run is deasserted, the period in progress completes. Its trailing edge still occurs, no further leading strobe follows, and the serial clock stays at the idle level.
- R9: Prescaler, scaler, double-rate and polarity are captured only at a start from idle. Changes while running take effect at the next start.
- R10: The fastest setting (prescaler code 0, scaler code 0, double-rate 1) gives a period of 2 bus clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| presc_sel_i | input | 2 | Prescaler select code |
| scale_sel_i | input | 4 | Scaler select code |
| dbl_rate_i | input | 1 | Double-rate bit (halves the period) |
| run_i | input | 1 | Run (1) or idle (0) request |
| cpol_i | input | 1 | Clock polarity, idle level of the serial clock |
| sck_o | output | 1 | Serial clock level |
| lead_o | output | 1 | One-cycle strobe on each leading edge |
| trail_o | output | 1 | One-cycle strobe on each trailing edge |

## Verification
Two events can fall in the same clock edge. The end of a period can coincide with a change of run, and a start from idle can coincide with a change of the configuration fields. The bench provokes both. It drops run in the middle of the first half and right after a leading strobe. It changes the prescaler one cycle after a start, and with the fastest 2-clock setting it restarts periods back to back. A behavioural model captures the configuration only at a start from idle and counts position within the period. It is compared with the serial clock and both strobes on every cycle. Directed interval and duty measurements confirm the period table and the stop behaviour.

// File: rtl/spi_rate_pkg.sv
package spi_rate_pkg;

    localparam int PRESC_SEL_W = 2;
    localparam int SCALE_SEL_W = 4;
    localparam int MAX_PERIOD  = 7 * 32768;
    localparam int PERIOD_W    = $clog2(MAX_PERIOD + 1);

    typedef logic [PERIOD_W-1:0] period_t;

    typedef struct packed {
        logic [PRESC_SEL_W-1:0] presc;
        logic [SCALE_SEL_W-1:0] scale;
        logic                   dbl;
        logic                   cpol;
    } rate_cfg_t;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_LEAD  = 2'd1,
        ST_TRAIL = 2'd2
    } seq_state_t;

    function automatic logic [2:0] presc_div(input logic [PRESC_SEL_W-1:0] code);
        logic [2:0] d;
        case (code)
            2'd0:    d = 3'd2;
            2'd1:    d = 3'd3;
            2'd2:    d = 3'd5;
            default: d = 3'd7;
        endcase
        return d;
    endfunction

    function automatic logic [15:0] scale_div(input logic [SCALE_SEL_W-1:0] code);
        logic [15:0] d;
        if (code < 4'd4) d = 16'({code, 1'b0}) + 16'd2;
        else             d = 16'd1 << code;
        return d;
    endfunction

    function automatic period_t period_of(input rate_cfg_t cfg);
        period_t prod;
        prod = period_t'(presc_div(cfg.presc)) * period_t'(scale_div(cfg.scale));
        return cfg.dbl ? (prod >> 1) : prod;
    endfunction

endpackage

// File: rtl/spi_rate_decode.sv
module spi_rate_decode
    import spi_rate_pkg::*;
(
    input  rate_cfg_t cfg_i,
    output period_t   lead_len_o,
    output period_t   trail_len_o
);
    period_t full_len;
    period_t high_len;
    period_t low_len;

    always_comb begin
        full_len = period_of(cfg_i);
        high_len = (full_len + period_t'(1)) >> 1;
        low_len  = full_len >> 1;
        // the half spent at the active level follows the leading edge
        if (cfg_i.cpol) begin
            lead_len_o  = low_len;
            trail_len_o = high_len;
        end else begin
            lead_len_o  = high_len;
            trail_len_o = low_len;
        end
    end
endmodule

// File: rtl/spi_rate_half_timer.sv
module spi_rate_half_timer #(
    parameter int W = 18
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_i,
    input  logic [W-1:0] len_i,
    output logic         expire_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (load_i)        cnt_q <= len_i - W'(1);
        else if (cnt_q != '0)   cnt_q <= cnt_q - W'(1);
    end

    assign expire_o = (cnt_q == '0);
endmodule

// File: rtl/spi_rate_seq.sv
module spi_rate_seq
    import spi_rate_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic run_i,
    input  logic expire_i,
    input  logic cpol_live_i,
    input  logic cpol_held_i,
    output logic start_o,
    output logic load_o,
    output logic use_trail_len_o,
    output logic busy_o,
    output logic sck_o,
    output logic lead_o,
    output logic trail_o
);
    seq_state_t st_q, st_d;
    logic sck_q, sck_d, lead_q, lead_d, trail_q, trail_d;

    always_comb begin
        st_d    = st_q;
        sck_d   = sck_q;
        lead_d  = 1'b0;
        trail_d = 1'b0;
        start_o = 1'b0;
        load_o  = 1'b0;
        case (st_q)
            ST_IDLE: begin
                sck_d = cpol_live_i;
                if (run_i) begin
                    start_o = 1'b1;
                    load_o  = 1'b1;
                    st_d    = ST_LEAD;
                    sck_d   = ~cpol_live_i;
                    lead_d  = 1'b1;
                end
            end
            ST_LEAD: begin
                if (expire_i) begin
                    load_o  = 1'b1;
                    st_d    = ST_TRAIL;
                    sck_d   = cpol_held_i;
                    trail_d = 1'b1;
                end
            end
            ST_TRAIL: begin
                if (expire_i) begin
                    if (run_i) begin
                        load_o = 1'b1;
                        st_d   = ST_LEAD;
                        sck_d  = ~cpol_held_i;
                        lead_d = 1'b1;
                    end else begin
                        st_d = ST_IDLE;
                    end
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            sck_q   <= cpol_live_i;
            lead_q  <= 1'b0;
            trail_q <= 1'b0;
        end else begin
            st_q    <= st_d;
            sck_q   <= sck_d;
            lead_q  <= lead_d;
            trail_q <= trail_d;
        end
    end

    assign use_trail_len_o = (st_q == ST_LEAD);
    assign busy_o          = (st_q != ST_IDLE);
    assign sck_o           = sck_q;
    assign lead_o          = lead_q;
    assign trail_o         = trail_q;
endmodule

// File: rtl/spi_rate_gen.sv
module spi_rate_gen
    import spi_rate_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst,
    input  logic [PRESC_SEL_W-1:0] presc_sel_i,
    input  logic [SCALE_SEL_W-1:0] scale_sel_i,
    input  logic                   dbl_rate_i,
    input  logic                   run_i,
    input  logic                   cpol_i,
    output logic                   sck_o,
    output logic                   lead_o,
    output logic                   trail_o
);
    rate_cfg_t cfg_live, cfg_q, cfg_use;
    period_t   lead_len, trail_len, load_len;
    logic      start, load, use_trail_len, busy, expire;

    assign cfg_live = '{presc: presc_sel_i, scale: scale_sel_i,
                        dbl: dbl_rate_i, cpol: cpol_i};

    always_ff @(posedge clk) begin
        if (rst)        cfg_q <= '0;
        else if (start) cfg_q <= cfg_live;
    end

    // at a start the fresh fields size the first half directly
    assign cfg_use  = start ? cfg_live : cfg_q;
    assign load_len = use_trail_len ? trail_len : lead_len;

    spi_rate_decode u_decode (
        .cfg_i       (cfg_use),
        .lead_len_o  (lead_len),
        .trail_len_o (trail_len)
    );

    spi_rate_half_timer #(.W(PERIOD_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load_i   (load),
        .len_i    (load_len),
        .expire_o (expire)
    );

    spi_rate_seq u_seq (
        .clk             (clk),
        .rst             (rst),
        .run_i           (run_i),
        .expire_i        (expire),
        .cpol_live_i     (cpol_i),
        .cpol_held_i     (cfg_q.cpol),
        .start_o         (start),
        .load_o          (load),
        .use_trail_len_o (use_trail_len),
        .busy_o          (busy),
        .sck_o           (sck_o),
        .lead_o          (lead_o),
        .trail_o         (trail_o)
    );
endmodule

// File: rtl/spi_rate_gen_chk.sv
module spi_rate_gen_chk
    import spi_rate_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input logic      sck,
    input logic      lead,
    input logic      trail,
    input logic      busy,
    input rate_cfg_t cfg_q
);
    a_r5_idle_quiet: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!lead && !trail));

    a_r6_lead_level: assert property (@(posedge clk) disable iff (rst)
        lead |-> (sck != cfg_q.cpol));

    a_r7_trail_level: assert property (@(posedge clk) disable iff (rst)
        trail |-> (sck == cfg_q.cpol));

    a_r7_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(lead && trail));

    a_r3_sck_quiet: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy) && !lead && !trail) |-> $stable(sck));

    a_r9_cfg_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cfg_q));
endmodule

bind spi_rate_gen spi_rate_gen_chk u_chk (
    .clk   (clk),
    .rst   (rst),
    .sck   (sck_o),
    .lead  (lead_o),
    .trail (trail_o),
    .busy  (busy),
    .cfg_q (cfg_q)
);

// File: tb/spi_rate_gen_bench.sv
module spi_rate_gen_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] presc = '0;
    logic [3:0] scale = '0;
    logic       dbl = 1'b0;
    logic       run = 1'b0;
    logic       cpol = 1'b0;
    logic       sck, lead, trail;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    spi_rate_gen u_spi_rate_gen (
        .clk (clk), .rst (rst), .presc_sel_i (presc), .scale_sel_i (scale),
        .dbl_rate_i (dbl), .run_i (run), .cpol_i (cpol),
        .sck_o (sck), .lead_o (lead), .trail_o (trail)
    );

    function automatic int bench_period(input int p, input int s, input int d);
        int pv[4]   = '{2, 3, 5, 7};
        int sv[16]  = '{2, 4, 6, 8, 16, 32, 64, 128, 256, 512, 1024,
                        2048, 4096, 8192, 16384, 32768};
        return (pv[p] * sv[s]) / (1 + d);
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // behavioural reference: position within the current period
    bit m_active = 0;
    int m_pos = 0, m_len = 0, m_first = 0;
    bit m_cpol = 0, e_sck = 0, e_lead = 0, e_trail = 0;

    always @(posedge clk) begin
        if (rst) begin
            m_active = 0; e_sck = cpol; e_lead = 0; e_trail = 0;
        end else begin
            e_lead = 0; e_trail = 0;
            if (!m_active) begin
                if (run) begin
                    m_active = 1; m_pos = 0; m_cpol = cpol;
                    m_len = bench_period(int'(presc), int'(scale), int'(dbl));
                    m_first = cpol ? m_len / 2 : (m_len + 1) / 2;
                    e_sck = !cpol; e_lead = 1;
                end else begin
                    e_sck = cpol;
                end
            end else begin
                m_pos++;
                if (m_pos == m_first) begin e_trail = 1; e_sck = m_cpol; end
                if (m_pos == m_len) begin
                    if (run) begin m_pos = 0; e_lead = 1; e_sck = !m_cpol; end
                    else m_active = 0;
                end
            end
        end
    end

    always @(negedge clk) begin
        if (!rst) begin
            if (lead !== e_lead)        check(0, "R6 model lead", int'(lead), int'(e_lead));
            else if (trail !== e_trail) check(0, "R7 model trail", int'(trail), int'(e_trail));
            else if (sck !== e_sck)     check(0, "R3 model sck", int'(sck), int'(e_sck));
            else                        check(1, "R3 model", 0, 0);
        end
    end

    task automatic summary();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        check(0, "watchdog", 0, 1);
        summary();
    end

    // one full period starting from idle, then a stop
    task automatic measure(input int p, input int s, input int d, input bit c,
                           input string tag);
        int exp_len, n, hi, leads;
        exp_len = bench_period(p, s, d);
        presc = 2'(p); scale = 4'(s); dbl = d[0]; cpol = c;
        @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        check(lead === 1'b1 && sck === !c, "R6 start lead", int'(lead), 1);
        n = 0; hi = int'(sck);
        forever begin
            @(negedge clk);
            if (lead === 1'b1 || n > 70000) break;
            n++;
            hi += int'(sck);
        end
        check(n + 1 == exp_len, tag, n + 1, exp_len);
        check(hi == (exp_len + 1) / 2, "R4 high half", hi, (exp_len + 1) / 2);
        run = 1'b0;
        leads = 0;
        repeat (2 * exp_len + 2) begin
            @(negedge clk);
            leads += int'(lead);
        end
        check(leads == 0, "R8 no lead after stop", leads, 0);
        check(sck === c, "R8 idle level", int'(sck), int'(c));
    endtask

    initial begin : main
        int n, trails, leads;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check(sck === 1'b0 && lead === 1'b0 && trail === 1'b0, "R5 reset idle", int'(sck), 0);
        cpol = 1'b1;
        @(negedge clk);
        check(sck === 1'b1, "R5 idle follows polarity", int'(sck), 1);
        check(lead === 1'b0 && trail === 1'b0, "R5 strobes low idle", int'(lead | trail), 0);
        cpol = 1'b0;
        @(negedge clk);

        measure(0, 0, 0, 0, "R1 presc code0");
        measure(1, 0, 0, 0, "R1 presc code1");
        measure(2, 0, 0, 0, "R1 presc code2");
        measure(3, 0, 0, 1, "R1 presc code3");
        for (int s = 1; s <= 9; s++) measure(0, s, 0, 0, "R2 scaler code");
        measure(1, 2, 0, 0, "R3 dbr off");
        measure(1, 2, 1, 0, "R3 dbr halves");
        measure(0, 0, 1, 0, "R10 fastest");
        measure(0, 0, 1, 1, "R10 fastest cpol1");
        measure(3, 0, 1, 0, "R4 odd period cpol0");
        measure(3, 0, 1, 1, "R4 odd period cpol1");
        measure(2, 0, 1, 1, "R4 odd period five");

        // R9: change presc right after the start
        presc = 2'd0; scale = 4'd0; dbl = 1'b0; cpol = 1'b0;
        @(negedge clk); run = 1'b1;
        @(negedge clk); presc = 2'd3;
        n = 1;
        forever begin @(negedge clk); if (lead === 1'b1 || n > 100) break; n++; end
        check(n == 4, "R9 cfg held while running", n, 4);
        run = 1'b0;
        repeat (12) @(negedge clk);
        run = 1'b1;
        @(negedge clk);
        n = 1;
        forever begin @(negedge clk); if (lead === 1'b1 || n > 100) break; n++; end
        check(n == 14, "R9 new cfg at next start", n, 14);
        run = 1'b0;
        repeat (30) @(negedge clk);

        // R8: stop in the middle of the first half
        presc = 2'd0; scale = 4'd2; dbl = 1'b0; cpol = 1'b0;
        run = 1'b1;
        @(negedge clk);
        @(negedge clk); @(negedge clk);
        run = 1'b0;
        trails = 0; leads = 0;
        repeat (30) begin
            @(negedge clk);
            trails += int'(trail);
            leads  += int'(lead);
        end
        check(trails == 1, "R8 trailing edge completes", trails, 1);
        check(leads == 0, "R8 no new period", leads, 0);
        check(sck === 1'b0, "R8 rests at idle", int'(sck), 0);
        summary();
    end
endmodule